// File: doc/BRIEF.md
# Software-Triggered ADC Channel-List Sequencer

This block is the register-mapped front end of an acquisition channel. A host on a 16-bit register bus loads a list of 8-bit conversion descriptors. Each descriptor names an input channel, a gain code, a unipolar or bipolar range, and single-ended or differential wiring. In software-triggered mode, a host read of the start address makes the block hand the next descriptor to an external converter with a one-cycle start pulse.

The converter returns a 12-bit offset-binary code with a valid strobe some cycles later. The block queues the code in a result FIFO. The host pops results from the data address and receives them in straight binary. The descriptor list is not consumed: it advances one entry per conversion and wraps to the first entry after the last one. A status word reports busy, the list and result levels, a sticky overflow flag and a half-full interrupt-pending flag. Any write to the status address clears that flag, and an interrupt output is gated by two enable bits.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, the status word reads 0x0004 (result FIFO empty, nothing else set), irq_o is 0 and conv_start_o is 0.
- R2: Bits 1:0 of the control word at offset 0x00 select the mode: 0 off, 1 software trigger, 2 scan, 3 external. A bus read of offset 0x00 starts a conversion only in mode 1. In modes 0, 2 and 3 such a read starts nothing.
- R3: A write to offset 0x10 appends bits 7:0 as a descriptor: 3:0 channel, 5:4 gain, 6 unipolar, 7 differential. With each start pulse, conv_entry_o carries the selected descriptor unchanged.
- R4: Each conversion uses the next descriptor in write order. After the last valid descriptor it wraps to the first. A write to a full list (16 entries) is ignored.
- R5: In the second control word at offset 0x02, bit 9 enables the descriptor list and bit 10 enables the result FIFO. While either bit is 0, that store is empty and writes or results aimed at it are dropped.
- R6: A read of offset 0x10 returns the oldest result with bit 11 inverted and bits 15:12 zero, and pops it. A read of an empty FIFO returns 0 and changes nothing.
- R7: The status word at offset 0x04 has these bits: 0 busy, 1 list full, 2 result empty, 3 result at least half full (4 of 8), 4 result full, 5 overflow, 8 half-full interrupt pending. All other bits are 0.
- R8: A start read while a conversion is busy is ignored. No second start pulse is issued until the result strobe has arrived.
- R9: A start read while the result FIFO is full issues no start, does not advance the list, and sets the sticky overflow bit.
- R10: Writing mode 0 cancels a busy conversion. Its late result strobe is discarded.
- R11: The pending bit 8 sets when the result level rises to half full. irq_o equals pending AND control bit 15 AND control bit 8. Any write to offset 0x04 clears pending and overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe, one cycle |
| bus_rd_i | input | 1 | Read strobe, one cycle; triggers side effects |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid in the cycle of bus_rd_i |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_entry_o | output | 8 | Descriptor of the conversion being started |
| conv_valid_i | input | 1 | Converter result strobe |
| conv_data_i | input | 12 | Converter result, offset binary |
| irq_o | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle. A start pulse is never issued in any mode other than software trigger, and never while a conversion is busy. An overflowed trigger starts nothing. Mode 0 always leaves the sequencer idle on the next cycle. The descriptor read index stays inside the valid part of the list, a push into a full FIFO leaves its level unchanged, and irq_o is only ever high when both enable bits are set. Other behaviours need the bench's scenarios to show them: which descriptor each start carries, the wrap order, the bit-11 inversion of returned data, the half-full and overflow flags with their clear, dropping a cancelled result, and flushing when a store is disabled.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int AW = 8;
  localparam int DW = 16;

  localparam logic [AW-1:0] A_CTRL1 = 8'h00;  // write: control, read: start
  localparam logic [AW-1:0] A_CTRL2 = 8'h02;
  localparam logic [AW-1:0] A_STAT  = 8'h04;  // read: status, write: clear
  localparam logic [AW-1:0] A_DATA  = 8'h10;  // write: descriptor, read: result

  localparam int C1_IRQ_EN = 15;
  localparam int C1_HF_EN  = 8;
  localparam int C2_RES_EN = 10;
  localparam int C2_LST_EN = 9;

  localparam int S_BUSY  = 0;
  localparam int S_LFULL = 1;
  localparam int S_EMPTY = 2;
  localparam int S_HALF  = 3;
  localparam int S_FULL  = 4;
  localparam int S_OVF   = 5;
  localparam int S_HFPND = 8;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_SW   = 2'd1,
    MODE_SCAN = 2'd2,
    MODE_EXT  = 2'd3
  } adc_mode_e;
endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    count_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             half_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [IW-1:0] wr_q, rd_q;
  logic [CW-1:0] count_q;
  logic do_push, do_pop;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign half_o  = (count_q >= CW'(DEPTH / 2));
  assign count_o = count_q;
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; count_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0; rd_q <= '0; count_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> $stable(count_q));
  p_empty_pop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> (count_q == '0));
endmodule

// File: rtl/adc_seq_chlist.sv
module adc_seq_chlist #(
  parameter int DEPTH = 16,
  parameter int EW = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          wr_i,
  input  logic [EW-1:0] data_i,
  input  logic          adv_i,
  output logic [EW-1:0] entry_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [EW-1:0] mem_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] idx_q;
  logic do_wr;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign entry_o = mem_q[idx_q];
  assign do_wr   = wr_i && !full_o && !flush_i;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[cnt_q[IW-1:0]] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; idx_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0; idx_q <= '0;
    end else begin
      if (do_wr) cnt_q <= cnt_q + 1'b1;
      // wrap after the last written descriptor
      if (adv_i && !empty_o)
        idx_q <= (CW'(idx_q) == cnt_q - 1'b1) ? '0 : idx_q + 1'b1;
    end
  end

  p_idx_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o |-> (CW'(idx_q) < cnt_q));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int EW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  adc_mode_e     mode_i,
  input  logic          list_empty_i,
  input  logic          res_full_i,
  input  logic [EW-1:0] entry_i,
  input  logic          conv_valid_i,
  output logic          start_o,
  output logic [EW-1:0] entry_o,
  output logic          busy_o,
  output logic          launch_o,
  output logic          ovf_set_o,
  output logic          accept_o
);
  logic busy_q, start_q, req;
  logic [EW-1:0] entry_q;

  assign req       = trig_i && (mode_i == MODE_SW) && !busy_q && !list_empty_i;
  assign launch_o  = req && !res_full_i;
  assign ovf_set_o = req && res_full_i;
  assign accept_o  = conv_valid_i && busy_q && (mode_i != MODE_OFF);
  assign start_o   = start_q;
  assign entry_o   = entry_q;
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; start_q <= 1'b0; entry_q <= '0;
    end else begin
      start_q <= launch_o;
      if (launch_o) entry_q <= entry_i;
      if (mode_i == MODE_OFF) busy_q <= 1'b0;
      else if (launch_o)      busy_q <= 1'b1;
      else if (conv_valid_i)  busy_q <= 1'b0;
    end
  end

  p_mode_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != MODE_SW) |=> !start_q);
  p_no_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !conv_valid_i) |=> !start_q);
  p_ovf_no_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set_o |=> !start_q);
  p_abort_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_OFF) |=> !busy_q);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int LIST_DEPTH = 16,
  parameter int RES_DEPTH  = 8,
  parameter int RES_W      = 12,
  parameter int EW         = 8,
  localparam int RCW = $clog2(RES_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  output logic             conv_start_o,
  output logic [EW-1:0]    conv_entry_o,
  input  logic             conv_valid_i,
  input  logic [RES_W-1:0] conv_data_i,
  output logic             irq_o
);
  logic [DW-1:0] ctrl1_q, ctrl2_q;
  logic ovf_q, hf_pend_q, half_d_q;
  adc_mode_e mode;

  logic list_wr, list_empty, list_full, list_adv;
  logic [EW-1:0] list_entry;
  logic res_pop, res_empty, res_full, res_half, res_push;
  logic [RES_W-1:0] res_head;
  logic [RCW-1:0] res_count;
  logic trig, busy, ovf_set, clr_wr;

  assign mode    = adc_mode_e'(ctrl1_q[1:0]);
  assign trig    = bus_rd_i && (bus_addr_i == A_CTRL1);
  assign list_wr = bus_wr_i && (bus_addr_i == A_DATA);
  assign res_pop = bus_rd_i && (bus_addr_i == A_DATA);
  assign clr_wr  = bus_wr_i && (bus_addr_i == A_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl1_q <= '0; ctrl2_q <= '0;
      ovf_q <= 1'b0; hf_pend_q <= 1'b0; half_d_q <= 1'b0;
    end else begin
      if (bus_wr_i && bus_addr_i == A_CTRL1) ctrl1_q <= bus_wdata_i;
      if (bus_wr_i && bus_addr_i == A_CTRL2) ctrl2_q <= bus_wdata_i;
      half_d_q <= res_half;
      if (clr_wr) begin
        ovf_q <= 1'b0; hf_pend_q <= 1'b0;
      end
      if (ovf_set) ovf_q <= 1'b1;
      if (res_half && !half_d_q) hf_pend_q <= 1'b1;
    end
  end

  adc_seq_chlist #(.DEPTH(LIST_DEPTH), .EW(EW)) u_list (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!ctrl2_q[C2_LST_EN]),
    .wr_i    (list_wr),
    .data_i  (bus_wdata_i[EW-1:0]),
    .adv_i   (list_adv),
    .entry_o (list_entry),
    .empty_o (list_empty),
    .full_o  (list_full)
  );

  adc_seq_fifo #(.WIDTH(RES_W), .DEPTH(RES_DEPTH)) u_res (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (!ctrl2_q[C2_RES_EN]),
    .push_i  (res_push),
    .data_i  (conv_data_i),
    .pop_i   (res_pop),
    .data_o  (res_head),
    .count_o (res_count),
    .empty_o (res_empty),
    .full_o  (res_full),
    .half_o  (res_half)
  );

  adc_seq_ctrl #(.EW(EW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .trig_i       (trig),
    .mode_i       (mode),
    .list_empty_i (list_empty),
    .res_full_i   (res_full),
    .entry_i      (list_entry),
    .conv_valid_i (conv_valid_i),
    .start_o      (conv_start_o),
    .entry_o      (conv_entry_o),
    .busy_o       (busy),
    .launch_o     (list_adv),
    .ovf_set_o    (ovf_set),
    .accept_o     (res_push)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_STAT) begin
      bus_rdata_o[S_BUSY]  = busy;
      bus_rdata_o[S_LFULL] = list_full;
      bus_rdata_o[S_EMPTY] = res_empty;
      bus_rdata_o[S_HALF]  = res_half;
      bus_rdata_o[S_FULL]  = res_full;
      bus_rdata_o[S_OVF]   = ovf_q;
      bus_rdata_o[S_HFPND] = hf_pend_q;
    end else if (bus_addr_i == A_DATA && !res_empty) begin
      // offset binary to straight binary: flip the MSB
      bus_rdata_o[RES_W-1:0] = res_head ^ {1'b1, {(RES_W-1){1'b0}}};
    end
  end

  assign irq_o = hf_pend_q && ctrl1_q[C1_IRQ_EN] && ctrl1_q[C1_HF_EN];

  p_irq_gate_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ctrl1_q[C1_IRQ_EN] && ctrl1_q[C1_HF_EN]));
  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_count <= RCW'(RES_DEPTH));
endmodule

// File: tb/adc_seq_top_test.sv
module adc_seq_top_test;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic start;
  logic [7:0] entry;
  logic cvalid;
  logic [11:0] cdata;
  logic irq;

  int checks = 0, errors = 0;
  int unsigned cnt = 0;
  logic [7:0] m_ent = '0;
  logic [7:0] lm[$];
  int lidx = 0;
  logic [15:0] expq[$];
  bit done = 0;

  always #2 clk = ~clk;

  adc_seq_top uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .conv_start_o(start),
    .conv_entry_o(entry), .conv_valid_i(cvalid), .conv_data_i(cdata), .irq_o(irq)
  );

  // converter model: result depends only on the descriptor
  always @(posedge clk) begin
    if (start) begin
      cnt <= LAT; m_ent <= entry;
    end else if (cnt > 0) cnt <= cnt - 1;
  end
  assign cvalid = (cnt == 1);
  assign cdata  = {m_ent, m_ent[7:4]};

  function automatic logic [15:0] conv_exp(input logic [7:0] e);
    logic [11:0] d = {e, e[7:4]};
    return {4'h0, d ^ 12'h800};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: a trigger read; on a start, pushes the expected result
  task automatic trig(input bit exp_start, input string req);
    logic [15:0] d;
    bus_rd(8'h00, d);
    chk(start == exp_start, req, {15'h0, start}, {15'h0, exp_start});
    if (exp_start && start) begin
      chk(entry == lm[lidx], "R3/R4 descriptor", {8'h0, entry}, {8'h0, lm[lidx]});
      expq.push_back(conv_exp(lm[lidx]));
      lidx = (lidx + 1) % lm.size();
    end
  endtask

  // monitor: pops a result and compares it with the queue head
  task automatic pop_chk(input string req);
    logic [15:0] d, e;
    bus_rd(8'h10, d);
    e = (expq.size() > 0) ? expq.pop_front() : 16'h0;
    chk(d == e, req, d, e);
  endtask

  task automatic stat_chk(input logic [15:0] mask, input logic [15:0] exp, input string req);
    logic [15:0] d;
    bus_rd(8'h04, d);
    chk((d & mask) == exp, req, d & mask, exp);
  endtask

  task automatic list_add(input logic [7:0] e);
    bus_wr(8'h10, {8'h0, e});
    lm.push_back(e);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    logic [15:0] d;
    idle(3);
    #1 chk(start == 1'b0 && irq == 1'b0, "R1 outputs", {14'h0, start, irq}, 16'h0);
    rst_n = 1'b1;
    stat_chk(16'hFFFF, 16'h0004, "R1 status");

    // basic sequence with wrap
    bus_wr(8'h02, 16'h0600);
    list_add(8'h05); list_add(8'hA3); list_add(8'h4F);
    bus_wr(8'h00, 16'h0001);
    for (int i = 0; i < 4; i++) begin
      trig(1'b1, "R2 sw start");
      idle(8);
      pop_chk("R6 result flip");
    end

    // busy
    trig(1'b1, "R2 sw start");
    stat_chk(16'h0001, 16'h0001, "R7 busy");
    trig(1'b0, "R8 ignored while busy");
    idle(8);
    stat_chk(16'h0001, 16'h0000, "R7 idle");
    pop_chk("R8 single result");

    // other modes
    bus_wr(8'h00, 16'h0002); trig(1'b0, "R2 scan mode");
    bus_wr(8'h00, 16'h0003); trig(1'b0, "R2 ext mode");
    bus_wr(8'h00, 16'h0000); trig(1'b0, "R2 off mode");

    // abort
    bus_wr(8'h00, 16'h0001);
    trig(1'b1, "R10 start");
    bus_wr(8'h00, 16'h0000);
    void'(expq.pop_back());
    idle(10);
    stat_chk(16'h0005, 16'h0004, "R10 cancelled result dropped");

    // half-full irq, full, overflow
    bus_wr(8'h00, 16'h8101);
    for (int i = 0; i < 4; i++) begin trig(1'b1, "R2 sw start"); idle(8); end
    stat_chk(16'h0118, 16'h0108, "R11 half pending");
    #1 chk(irq == 1'b1, "R11 irq", {15'h0, irq}, 16'h1);
    for (int i = 0; i < 4; i++) begin trig(1'b1, "R2 sw start"); idle(8); end
    stat_chk(16'h0014, 16'h0010, "R7 full");
    trig(1'b0, "R9 no start when full");
    stat_chk(16'h0020, 16'h0020, "R9 overflow sticky");
    bus_wr(8'h04, 16'h0000);
    stat_chk(16'h0120, 16'h0000, "R11 clear");
    #1 chk(irq == 1'b0, "R11 irq cleared", {15'h0, irq}, 16'h0);
    for (int i = 0; i < 8; i++) pop_chk("R6 drain");
    bus_rd(8'h10, d);
    chk(d == 16'h0, "R6 empty read", d, 16'h0);
    stat_chk(16'h0004, 16'h0004, "R6 empty unchanged");
    bus_wr(8'h00, 16'h0101);
    trig(1'b1, "R9 list not advanced");
    idle(8);
    #1 chk(irq == 1'b0, "R11 irq gated", {15'h0, irq}, 16'h0);

    // result flush
    bus_wr(8'h02, 16'h0200);
    stat_chk(16'h0004, 16'h0004, "R5 result flush");
    void'(expq.pop_back());
    bus_wr(8'h02, 16'h0600);
    bus_rd(8'h10, d);
    chk(d == 16'h0, "R5 flushed read", d, 16'h0);

    // list flush and disabled write
    bus_wr(8'h02, 16'h0400);
    bus_wr(8'h10, 16'h0077);
    bus_wr(8'h02, 16'h0600);
    lm.delete(); lidx = 0;
    trig(1'b0, "R5 list flushed");

    // full list, ignored 17th write, wrap
    for (int i = 0; i < 16; i++) list_add(8'h10 + 8'(i * 3));
    stat_chk(16'h0002, 16'h0002, "R7 list full");
    bus_wr(8'h10, 16'h00EE);
    for (int i = 0; i < 17; i++) begin
      trig(1'b1, "R4 wrap");
      idle(8);
      pop_chk("R4 wrap result");
    end

    done = 1;
    finish_run();
  end
endmodule